// File: doc/BRIEF.md
# Four-Channel DAC Serial Command Front End

This block is the digital side of a four-channel, 10-bit digital-to-analog converter. A host sends 16-bit command words over a three- or four-wire serial link: serial clock, serial data, a frame-start strobe and an optional active-low select. Each word names one of four channels and carries three things for it: a 10-bit output code, a power-off flag and a fast-settling flag. The block stores these values in that channel's holding register.

Every channel has two stages: a holding register and an output latch. An active-low load strobe moves all four holding registers into their output latches at the same instant. While the strobe is held low, each latch instead follows its holding register as soon as a word commits. An active-low power-down pin reports every channel as off while it is low. It does not disturb any stored value.

All serial pins are sampled by a system clock that runs at least four times faster than the serial clock. Each pin passes through a two-flop synchroniser, and edges are detected in the system clock domain. The analog part is not included. The outputs are the four codes plus per-channel off and fast flags.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset every channel reports code 0, off flag 0 and fast flag 0 (with the power-down pin high).
- R2: While the select pin is high, serial activity changes no channel.
- R3: Word bits are taken MSB first, one on each falling serial clock edge. Bits 15:14 are the channel number (00, 01, 10, 11 for channels 0 to 3). Bit 13 set means off. Bit 12 set means fast. Bits 11:2 are the code. Bits 1:0 have no effect. Only the addressed channel changes.
- R4: After a full 16-bit word the value commits on the first rising serial clock edge after the sixteenth falling edge, and not before it.
- R5: If the frame strobe rises after at least 4 but fewer than 16 bits, the word commits at once. The bits received fill the word from bit 15 downward, and every bit not received reads as zero.
- R6: If the frame strobe rises after fewer than 4 bits, the word is discarded.
- R7: Serial clock edges after a committed word are ignored until the frame strobe falls again.
- R8: While the load strobe is high, the channel outputs hold their values. A falling edge of the load strobe moves all four holding registers to the outputs together.
- R9: While the load strobe is held low, the addressed channel's outputs take the new values when the word commits.
- R10: While the power-down pin is low, all four off flags read 1. When the pin returns high, the stored flags and codes reappear unchanged.
- R11: A word sent as two 8-bit bursts, with a pause between them and a single frame-strobe fall before the first burst, is accepted as one word.
- R12: If the select pin rises part-way through a word, the word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| din_i | input | 1 | Serial data, MSB first |
| fs_i | input | 1 | Frame strobe; a falling edge starts a word, a rising edge ends it early |
| cs_n_i | input | 1 | Active-low select; tie low for three-wire use |
| ldac_n_i | input | 1 | Active-low load strobe for simultaneous update |
| pd_n_i | input | 1 | Active-low power-down for all channels |
| chan_code_o | output | 40 | Four 10-bit codes, channel 0 in bits 9:0 |
| chan_off_o | output | 4 | Per-channel off flag |
| chan_fast_o | output | 4 | Per-channel fast-settling flag |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and an early-commit minimum of four bits. With a four-bit minimum, a 3-bit abort lands one bit below the threshold and an 8-bit early stop lands above it, so both sides of the boundary are tested. The serial clock half period is four system clocks. This keeps every serial edge visible after synchronisation and leaves room to check that nothing commits between the sixteenth falling edge and the rising edge after it.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int CODE_W    = 10;
    localparam int N_CH      = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(WORD_W + 1);
    localparam int CTRL_BITS = ADDR_W + 2;
    localparam int CODE_LSB  = WORD_W - CTRL_BITS - CODE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] chan;
        logic              off;
        logic              fast;
        logic [CODE_W-1:0] code;
    } cmd_t;

    typedef struct packed {
        logic              off;
        logic              fast;
        logic [CODE_W-1:0] code;
    } chan_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_WAIT_RISE
    } rx_state_e;

    // Split a 16-bit word into its command fields
    function automatic cmd_t unpack_word(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.chan = w[WORD_W-1 -: ADDR_W];
        c.off  = w[WORD_W-ADDR_W-1];
        c.fast = w[WORD_W-ADDR_W-2];
        c.code = w[CODE_LSB +: CODE_W];
        return c;
    endfunction

    // Move n received bits up to the top of the word, zero below them
    function automatic logic [WORD_W-1:0] align_partial(input logic [WORD_W-1:0] sr,
                                                        input logic [CNT_W-1:0] n);
        return sr << (WORD_W - int'(n));
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/qdac_edge.sv
module qdac_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] s_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= s_i;
    end

    assign rise_o = s_i & ~prev;
    assign fall_o = ~s_i & prev;
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
#(
    parameter int MIN_BITS = CTRL_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic din_s,
    input  logic cs_n_s,
    input  logic sclk_rise,
    input  logic sclk_fall,
    input  logic fs_rise,
    input  logic fs_fall,
    output logic commit_o,
    output cmd_t cmd_o
);
    rx_state_e         state;
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            sr       <= '0;
            cnt      <= '0;
            commit_o <= 1'b0;
            cmd_o    <= '0;
        end else begin
            commit_o <= 1'b0;
            if (cs_n_s) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (fs_fall) begin
                            state <= RX_SHIFT;
                            cnt   <= '0;
                            sr    <= '0;
                        end
                    end
                    RX_SHIFT: begin
                        if (fs_rise) begin
                            state <= RX_IDLE;
                            if (cnt >= CNT_W'(MIN_BITS)) begin
                                commit_o <= 1'b1;
                                cmd_o    <= unpack_word(align_partial(sr, cnt));
                            end
                        end else if (sclk_fall) begin
                            sr  <= {sr[WORD_W-2:0], din_s};
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(WORD_W - 1)) state <= RX_WAIT_RISE;
                        end
                    end
                    RX_WAIT_RISE: begin
                        if (sclk_rise || fs_rise) begin
                            commit_o <= 1'b1;
                            cmd_o    <= unpack_word(sr);
                            state    <= RX_IDLE;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit_i,
    input  cmd_t                     cmd_i,
    input  logic                     ldac_n_s,
    input  logic                     pd_n_s,
    output logic [N_CH-1:0]          wr_en_o,
    output logic [N_CH*CODE_W-1:0]   code_o,
    output logic [N_CH-1:0]          off_o,
    output logic [N_CH-1:0]          fast_o
);
    logic        ldac_prev;
    logic        ldac_fall;
    chan_state_t new_val;

    always_ff @(posedge clk) begin
        if (rst) ldac_prev <= 1'b1;
        else     ldac_prev <= ldac_n_s;
    end

    assign ldac_fall = ldac_prev & ~ldac_n_s;
    assign new_val   = '{off: cmd_i.off, fast: cmd_i.fast, code: cmd_i.code};

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        chan_state_t in_q;
        chan_state_t out_q;
        logic        sel;

        assign sel        = commit_i && (cmd_i.chan == ADDR_W'(g));
        assign wr_en_o[g] = sel;

        always_ff @(posedge clk) begin
            if (rst) begin
                in_q  <= '0;
                out_q <= '0;
            end else begin
                if (sel) in_q <= new_val;
                if (sel && !ldac_n_s) out_q <= new_val;
                else if (ldac_fall)   out_q <= in_q;
            end
        end

        assign code_o[g*CODE_W +: CODE_W] = out_q.code;
        assign off_o[g]                   = out_q.off | ~pd_n_s;
        assign fast_o[g]                  = out_q.fast;
    end
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_BITS    = CTRL_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sclk_i,
    input  logic                   din_i,
    input  logic                   fs_i,
    input  logic                   cs_n_i,
    input  logic                   ldac_n_i,
    input  logic                   pd_n_i,
    output logic [N_CH*CODE_W-1:0] chan_code_o,
    output logic [N_CH-1:0]        chan_off_o,
    output logic [N_CH-1:0]        chan_fast_o
);
    logic       din_s, sclk_s, fs_s, cs_n_s, ldac_n_s, pd_n_s;
    logic [1:0] rise, fall;
    logic       commit;
    cmd_t       cmd;
    logic [N_CH-1:0] wr_en;

    qdac_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b011111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({din_i, sclk_i, fs_i, cs_n_i, ldac_n_i, pd_n_i}),
        .q_o ({din_s, sclk_s, fs_s, cs_n_s, ldac_n_s, pd_n_s})
    );

    qdac_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .s_i    ({sclk_s, fs_s}),
        .rise_o (rise),
        .fall_o (fall)
    );

    qdac_frame_rx #(.MIN_BITS(MIN_BITS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .din_s     (din_s),
        .cs_n_s    (cs_n_s),
        .sclk_rise (rise[1]),
        .sclk_fall (fall[1]),
        .fs_rise   (rise[0]),
        .fs_fall   (fall[0]),
        .commit_o  (commit),
        .cmd_o     (cmd)
    );

    qdac_chan_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .cmd_i    (cmd),
        .ldac_n_s (ldac_n_s),
        .pd_n_s   (pd_n_s),
        .wr_en_o  (wr_en),
        .code_o   (chan_code_o),
        .off_o    (chan_off_o),
        .fast_o   (chan_fast_o)
    );
endmodule

// File: rtl/qdac_serial_front_chk.sv
module qdac_serial_front_chk
    import qdac_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   cs_n_s,
    input logic                   ldac_n_s,
    input logic                   pd_n_s,
    input logic                   commit,
    input logic [N_CH-1:0]        wr_en,
    input logic [N_CH*CODE_W-1:0] chan_code_o,
    input logic [N_CH-1:0]        chan_off_o,
    input logic [N_CH-1:0]        chan_fast_o
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_code_o == '0 && chan_fast_o == '0));

    p_cs_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !commit);

    p_one_channel_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    p_single_commit_r4: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    p_hold_ldac_r8: assert property (@(posedge clk) disable iff (rst)
        ldac_n_s |=> $stable(chan_code_o));

    p_pd_all_off_r10: assert property (@(posedge clk) disable iff (rst)
        !pd_n_s |-> (&chan_off_o));
endmodule

bind qdac_serial_front qdac_serial_front_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n_s      (cs_n_s),
    .ldac_n_s    (ldac_n_s),
    .pd_n_s      (pd_n_s),
    .commit      (commit),
    .wr_en       (wr_en),
    .chan_code_o (chan_code_o),
    .chan_off_o  (chan_off_o),
    .chan_fast_o (chan_fast_o)
);

// File: tb/qdac_serial_front_tb_top.sv
module qdac_serial_front_tb_top;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, din = 1'b0, fs = 1'b1, cs_n = 1'b0, ldac_n = 1'b0, pd_n = 1'b1;
    logic [39:0] chan_code_o;
    logic [3:0]  chan_off_o, chan_fast_o;

    int checks = 0;
    int bad    = 0;

    logic [9:0] m_in_code[4], m_out_code[4];
    logic       m_in_off[4], m_out_off[4], m_in_fast[4], m_out_fast[4];

    always #2 clk = ~clk;

    qdac_serial_front dut_i (
        .clk (clk), .rst (rst), .sclk_i (sclk), .din_i (din), .fs_i (fs),
        .cs_n_i (cs_n), .ldac_n_i (ldac_n), .pd_n_i (pd_n),
        .chan_code_o (chan_code_o), .chan_off_o (chan_off_o), .chan_fast_o (chan_fast_o)
    );

    function automatic logic [15:0] mk(input logic [1:0] ch, input logic off, input logic fast,
                                       input logic [9:0] code, input logic [1:0] junk);
        return {ch, off, fast, code, junk};
    endfunction

    task automatic model_commit(input logic [15:0] w);
        int c = int'(w[15:14]);
        m_in_code[c] = w[11:2]; m_in_off[c] = w[13]; m_in_fast[c] = w[12];
        if (!ldac_n) begin
            m_out_code[c] = w[11:2]; m_out_off[c] = w[13]; m_out_fast[c] = w[12];
        end
    endtask

    task automatic model_load();
        for (int c = 0; c < 4; c++) begin
            m_out_code[c] = m_in_code[c]; m_out_off[c] = m_in_off[c]; m_out_fast[c] = m_in_fast[c];
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++) begin
            logic [11:0] got, exp;
            got = {chan_code_o[c*10 +: 10], chan_off_o[c], chan_fast_o[c]};
            exp = {m_out_code[c], m_out_off[c] | ~pd_n, m_out_fast[c]};
            checks++;
            if (got !== exp) begin
                bad++;
                $display("FAIL %s ch%0d actual=%h expected=%h", tag, c, got, exp);
            end
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int nbits, input bit last_rise);
        for (int i = 0; i < nbits; i++) begin
            din = w[15-i];
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
            if (i != nbits - 1 || last_rise) begin
                sclk = 1'b1;
                wait_clk(HALF);
            end
        end
    endtask

    task automatic frame_start();
        fs = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        fs = 1'b1;
        wait_clk(12);
    endtask

    task automatic send_word(input logic [15:0] w);
        frame_start();
        shift_bits(w, 16, 1'b1);
        frame_end();
        model_commit(w);
    endtask

    // R1: reset state
    task automatic t_reset();
        for (int c = 0; c < 4; c++) begin
            m_in_code[c] = '0; m_out_code[c] = '0;
            m_in_off[c] = 1'b0; m_out_off[c] = 1'b0;
            m_in_fast[c] = 1'b0; m_out_fast[c] = 1'b0;
        end
        check_all("R1");
    endtask

    // R3, R9: field layout, addressing, direct update with load held low
    task automatic t_fields();
        send_word(mk(2'b00, 1'b0, 1'b1, 10'h2A5, 2'b11));
        send_word(mk(2'b01, 1'b0, 1'b0, 10'h15A, 2'b01));
        send_word(mk(2'b10, 1'b0, 1'b1, 10'h3FF, 2'b10));
        send_word(mk(2'b11, 1'b1, 1'b0, 10'h001, 2'b00));
        check_all("R3");
        send_word(mk(2'b01, 1'b1, 1'b1, 10'h0F0, 2'b00));
        check_all("R9");
    endtask

    // R4: no commit until the rising edge after the 16th falling edge
    task automatic t_commit_edge();
        logic [15:0] w = mk(2'b00, 1'b0, 1'b0, 10'h133, 2'b00);
        frame_start();
        shift_bits(w, 16, 1'b0);
        wait_clk(10);
        check_all("R4");
        sclk = 1'b1;
        wait_clk(8);
        model_commit(w);
        check_all("R4");
        frame_end();
    endtask

    // R2: select high blocks
    task automatic t_cs_high();
        cs_n = 1'b1;
        wait_clk(8);
        frame_start();
        shift_bits(mk(2'b00, 1'b1, 1'b1, 10'h3C3, 2'b00), 16, 1'b1);
        frame_end();
        cs_n = 1'b0;
        wait_clk(8);
        check_all("R2");
    endtask

    // R6: fewer than 4 bits discarded, then a good word still works
    task automatic t_short_abort();
        frame_start();
        shift_bits(mk(2'b10, 1'b1, 1'b0, 10'h000, 2'b00), 3, 1'b1);
        frame_end();
        check_all("R6");
        send_word(mk(2'b10, 1'b0, 1'b0, 10'h0AA, 2'b00));
        check_all("R6");
    endtask

    // R5: early end after 8 bits, missing bits read zero
    task automatic t_early();
        logic [15:0] w = mk(2'b10, 1'b0, 1'b1, 10'h2B3, 2'b11);
        frame_start();
        shift_bits(w, 8, 1'b1);
        frame_end();
        model_commit({w[15:8], 8'h00});
        check_all("R5");
    endtask

    // R7: extra clocks after a full word are ignored
    task automatic t_extra_bits();
        logic [15:0] w = mk(2'b11, 1'b0, 1'b1, 10'h155, 2'b00);
        frame_start();
        shift_bits(w, 16, 1'b1);
        shift_bits(16'hFFFF, 6, 1'b1);
        frame_end();
        model_commit(w);
        check_all("R7");
    endtask

    // R11: two 8-bit bursts with a pause
    task automatic t_two_bytes();
        logic [15:0] w = mk(2'b01, 1'b0, 1'b1, 10'h26D, 2'b00);
        frame_start();
        shift_bits(w, 8, 1'b1);
        wait_clk(24);
        shift_bits({w[7:0], 8'h00}, 8, 1'b1);
        frame_end();
        model_commit(w);
        check_all("R11");
    endtask

    // R12: select rising mid-word drops it
    task automatic t_cs_abort();
        frame_start();
        shift_bits(mk(2'b00, 1'b1, 1'b1, 10'h3FF, 2'b00), 10, 1'b1);
        cs_n = 1'b1;
        wait_clk(8);
        fs = 1'b1;
        wait_clk(8);
        cs_n = 1'b0;
        wait_clk(8);
        check_all("R12");
    endtask

    // R10: power-down overrides flags, keeps contents
    task automatic t_power_down();
        pd_n = 1'b0;
        wait_clk(8);
        checks++;
        if (chan_off_o !== 4'hF) begin
            bad++;
            $display("FAIL R10 off actual=%h expected=f", chan_off_o);
        end
        check_all("R10");
        pd_n = 1'b1;
        wait_clk(8);
        check_all("R10");
    endtask

    // R8: load high holds, falling edge loads all channels
    task automatic t_load();
        ldac_n = 1'b1;
        wait_clk(8);
        send_word(mk(2'b00, 1'b0, 1'b1, 10'h321, 2'b00));
        send_word(mk(2'b11, 1'b0, 1'b0, 10'h08F, 2'b00));
        check_all("R8");
        ldac_n = 1'b0;
        wait_clk(8);
        model_load();
        check_all("R8");
        ldac_n = 1'b1;
        wait_clk(8);
        check_all("R8");
        ldac_n = 1'b0;
        wait_clk(8);
        model_load();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks + 1, bad);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(8);
        t_reset();
        t_fields();
        t_commit_edge();
        t_cs_high();
        t_short_abort();
        t_early();
        t_extra_bits();
        t_two_bytes();
        t_cs_abort();
        t_power_down();
        t_load();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule